// File: doc/BRIEF.md
# Event Acceptance and Vectoring Unit

This unit sits beside a processor core's control path and decides, every clock, whether one of the pending events may be taken. The events are grouped into three classes. Critical events can never be masked. Ordinary exceptions are gated by an exception mask and a global mask. Four interrupt levels are each gated by their own level mask and by the global mask. The unit resolves the highest-priority eligible request and reports it with a single-cycle accept strobe, together with a class code and an event number. It also gives the program counter where the handler starts.

The handler address is the vector base combined with an offset by a bitwise OR. It is never their sum. Exceptions use constant offsets computed from parameters. Interrupt levels use a 14-bit autovector offset that the interrupt controller supplies for each level. The unit owns the mask and mode fields of the status register. On acceptance, in the same clock edge, it masks every source of equal or lower priority and writes the mode code of the accepted event. Software or a return sequence can load both fields through a load port. The unit stores no requests: a source holds its line until it sees the strobe.

Top module: `evu_top`

## Requirements
- R1: While reset is asserted the mask field is all ones (6'b111111) and the mode field is 3'd1; both remain so on the first cycle after reset.
- R2: Fixed priority from highest to lowest: critical lines (line 0 first), exception lines (line 0 first), INT3, INT2, INT1, INT0. Event numbers are assigned in that order: critical line i is i, exception line j is NUM_CRIT+j, and interrupt level k is NUM_CRIT+NUM_EXC+3-k. Class codes are 0 none, 1 critical, 2 exception, 3 interrupt.
- R3: Mask bit positions are: bit k (k=0..3) masks interrupt level k, bit 4 masks all exceptions, and bit 5 (global) masks all exceptions and all interrupt levels. A masked request produces no strobe and no state change.
- R4: A critical request is accepted whatever the mask field holds, provided no status load is in progress.
- R5: The handler address is the vector base bitwise-OR a 14-bit offset. For event number e of an exception or critical event, the offset is (EXC_OFS0 + e*EXC_STRIDE) mod 2^14. For interrupt level k, the offset is autovector bits [14k+13:14k].
- R6: Accepting a critical event or an exception sets all six mask bits. Accepting interrupt level k sets mask bits k down to 0 and leaves the other bits unchanged.
- R7: On acceptance the mode field becomes 7 for a critical event, 6 for an exception and 2+k for interrupt level k.
- R8: Requests are not stored: a request that is masked, or that is dropped before it is accepted, leaves nothing behind, and a request still held when its mask clears is accepted in that cycle.
- R9: A status load writes the mask and mode inputs at the next edge, and no event is accepted in a load cycle.
- R10: In a cycle with no acceptance and no load, the mask and mode fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| crit_req_i | input | NUM_CRIT | Critical event request lines |
| exc_req_i | input | NUM_EXC | Ordinary exception request lines |
| int_req_i | input | 4 | Interrupt level requests, bit k is level k |
| sr_load_i | input | 1 | Load mask and mode fields |
| sr_mask_i | input | 6 | Mask value to load |
| sr_mode_i | input | 3 | Mode value to load |
| evba_i | input | ADDR_W | Vector base |
| autovec_i | input | 4*OFS_W | Autovector offsets, level k at slice k |
| acc_o | output | 1 | Accept strobe, one cycle |
| evt_cls_o | output | 2 | Class of the accepted event |
| evt_id_o | output | ID_W | Number of the accepted event |
| handler_pc_o | output | ADDR_W | Handler start address |
| mask_o | output | 6 | Current mask field |
| mode_o | output | 3 | Current mode field |

## Verification
The bench builds the unit with two critical lines and three exception lines. The exception offsets start at 0x20 with a stride of 0x80. With these values every class and every event number occurs often under random requests. The exception offsets also carry bits that overlap random low bits of the vector base, so an adder in place of the OR produces different addresses in most cycles. A directed base of 0x8000_0030 fixes one case where OR and sum differ.

// File: rtl/evu_pkg.sv
package evu_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_CRIT = 2'd1,
        CLS_EXC  = 2'd2,
        CLS_INT  = 2'd3
    } evt_cls_e;

    localparam int MSK_W   = 6;
    localparam int MODE_W  = 3;
    localparam int NUM_LVL = 4;
    localparam int MB_EXC  = 4;
    localparam int MB_GLB  = 5;

    localparam logic [MODE_W-1:0] MODE_RESET = 3'd1;
    localparam logic [MODE_W-1:0] MODE_INT0  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_EXC   = 3'd6;
    localparam logic [MODE_W-1:0] MODE_CRIT  = 3'd7;
    localparam logic [MSK_W-1:0]  MASK_ALL   = '1;

    typedef struct packed {
        logic [MSK_W-1:0]  mask;
        logic [MODE_W-1:0] mode;
    } sr_t;

endpackage

// File: rtl/evu_prio.sv
module evu_prio
    import evu_pkg::*;
#(
    parameter int NUM_CRIT = 4,
    parameter int NUM_EXC  = 8,
    parameter int ID_W     = 4
) (
    input  logic [NUM_CRIT-1:0] crit_req,
    input  logic [NUM_EXC-1:0]  exc_req,
    input  logic [NUM_LVL-1:0]  int_req,
    input  logic [MSK_W-1:0]    mask,
    output logic                hit,
    output evt_cls_e            cls,
    output logic [ID_W-1:0]     id,
    output logic [1:0]          lvl
);
    localparam int NTOT     = NUM_CRIT + NUM_EXC + NUM_LVL;
    localparam int INT_BASE = NUM_CRIT + NUM_EXC;

    logic [NTOT-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < NUM_CRIT; g++) begin : g_crit
            assign elig[g] = crit_req[g];
        end
        for (g = 0; g < NUM_EXC; g++) begin : g_exc
            assign elig[NUM_CRIT+g] = exc_req[g] & ~mask[MB_EXC] & ~mask[MB_GLB];
        end
        for (g = 0; g < NUM_LVL; g++) begin : g_lvl
            assign elig[INT_BASE+NUM_LVL-1-g] = int_req[g] & ~mask[g] & ~mask[MB_GLB];
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int i = NTOT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                id  = ID_W'(i);
            end
        end
    end

    always_comb begin
        if (!hit)                          cls = CLS_NONE;
        else if (int'(id) < NUM_CRIT)      cls = CLS_CRIT;
        else if (int'(id) < INT_BASE)      cls = CLS_EXC;
        else                               cls = CLS_INT;
        lvl = 2'(NTOT - 1 - int'(id));
    end

endmodule

// File: rtl/evu_vec.sv
module evu_vec
    import evu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFS_W      = 14,
    parameter int NUM_CRIT   = 4,
    parameter int NUM_EXC    = 8,
    parameter int ID_W       = 4,
    parameter int EXC_OFS0   = 'h20,
    parameter int EXC_STRIDE = 'h40
) (
    input  logic                       hit,
    input  evt_cls_e                   cls,
    input  logic [ID_W-1:0]            id,
    input  logic [1:0]                 lvl,
    input  logic [ADDR_W-1:0]          evba,
    input  logic [NUM_LVL*OFS_W-1:0]   autovec,
    output logic [ADDR_W-1:0]          pc
);
    localparam int NFIX = NUM_CRIT + NUM_EXC;

    logic [OFS_W-1:0] fix_ofs [NFIX];
    logic [OFS_W-1:0] lvl_ofs [NUM_LVL];
    logic [OFS_W-1:0] sel_ofs;

    genvar g;
    generate
        for (g = 0; g < NFIX; g++) begin : g_fix
            assign fix_ofs[g] = OFS_W'(EXC_OFS0 + g * EXC_STRIDE);
        end
        for (g = 0; g < NUM_LVL; g++) begin : g_av
            assign lvl_ofs[g] = autovec[g*OFS_W +: OFS_W];
        end
    endgenerate

    always_comb begin
        sel_ofs = '0;
        if (cls == CLS_INT) begin
            sel_ofs = lvl_ofs[lvl];
        end else begin
            for (int i = 0; i < NFIX; i++) begin
                if (int'(id) == i) sel_ofs = fix_ofs[i];
            end
        end
        pc = hit ? (evba | {{(ADDR_W-OFS_W){1'b0}}, sel_ofs}) : '0;
    end

endmodule

// File: rtl/evu_sr_next.sv
module evu_sr_next
    import evu_pkg::*;
(
    input  evt_cls_e            cls,
    input  logic [1:0]          lvl,
    input  sr_t                 cur,
    output sr_t                 nxt
);
    logic [NUM_LVL-1:0] lvl_fill;

    genvar g;
    generate
        for (g = 0; g < NUM_LVL; g++) begin : g_fill
            assign lvl_fill[g] = (lvl >= 2'(g));
        end
    endgenerate

    always_comb begin
        nxt = cur;
        unique case (cls)
            CLS_CRIT: begin
                nxt.mask = MASK_ALL;
                nxt.mode = MODE_CRIT;
            end
            CLS_EXC: begin
                nxt.mask = MASK_ALL;
                nxt.mode = MODE_EXC;
            end
            CLS_INT: begin
                nxt.mask = cur.mask | {2'b00, lvl_fill};
                nxt.mode = MODE_INT0 + MODE_W'(lvl);
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/evu_top.sv
module evu_top
    import evu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFS_W      = 14,
    parameter int NUM_CRIT   = 4,
    parameter int NUM_EXC    = 8,
    parameter int EXC_OFS0   = 'h20,
    parameter int EXC_STRIDE = 'h40,
    localparam int ID_W      = $clog2(NUM_CRIT + NUM_EXC + 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CRIT-1:0]   crit_req_i,
    input  logic [NUM_EXC-1:0]    exc_req_i,
    input  logic [3:0]            int_req_i,
    input  logic                  sr_load_i,
    input  logic [5:0]            sr_mask_i,
    input  logic [2:0]            sr_mode_i,
    input  logic [ADDR_W-1:0]     evba_i,
    input  logic [4*OFS_W-1:0]    autovec_i,
    output logic                  acc_o,
    output logic [1:0]            evt_cls_o,
    output logic [ID_W-1:0]       evt_id_o,
    output logic [ADDR_W-1:0]     handler_pc_o,
    output logic [5:0]            mask_o,
    output logic [2:0]            mode_o
);
    sr_t              st_d, st_q, st_acc;
    logic             hit;
    evt_cls_e         cls;
    logic [ID_W-1:0]  id;
    logic [1:0]       lvl;

    evu_prio #(
        .NUM_CRIT (NUM_CRIT),
        .NUM_EXC  (NUM_EXC),
        .ID_W     (ID_W)
    ) u_prio (
        .crit_req (crit_req_i),
        .exc_req  (exc_req_i),
        .int_req  (int_req_i),
        .mask     (st_q.mask),
        .hit      (hit),
        .cls      (cls),
        .id       (id),
        .lvl      (lvl)
    );

    evu_vec #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .NUM_CRIT   (NUM_CRIT),
        .NUM_EXC    (NUM_EXC),
        .ID_W       (ID_W),
        .EXC_OFS0   (EXC_OFS0),
        .EXC_STRIDE (EXC_STRIDE)
    ) u_vec (
        .hit     (hit),
        .cls     (cls),
        .id      (id),
        .lvl     (lvl),
        .evba    (evba_i),
        .autovec (autovec_i),
        .pc      (handler_pc_o)
    );

    evu_sr_next u_srn (
        .cls (cls),
        .lvl (lvl),
        .cur (st_q),
        .nxt (st_acc)
    );

    always_comb begin
        st_d  = st_q;
        acc_o = 1'b0;
        if (sr_load_i) begin
            st_d.mask = sr_mask_i;
            st_d.mode = sr_mode_i;
        end else if (hit) begin
            acc_o = 1'b1;
            st_d  = st_acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MASK_ALL;
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_cls_o = acc_o ? cls : CLS_NONE;
    assign evt_id_o  = acc_o ? id  : '0;
    assign mask_o    = st_q.mask;
    assign mode_o    = st_q.mode;

endmodule

// File: rtl/evu_chk.sv
module evu_chk
    import evu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFS_W    = 14,
    parameter int NUM_CRIT = 4,
    parameter int NUM_EXC  = 8,
    parameter int ID_W     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CRIT-1:0] crit_req_i,
    input logic                sr_load_i,
    input logic [5:0]          sr_mask_i,
    input logic [2:0]          sr_mode_i,
    input logic [ADDR_W-1:0]   evba_i,
    input logic                acc_o,
    input logic [1:0]          evt_cls_o,
    input logic [ID_W-1:0]     evt_id_o,
    input logic [ADDR_W-1:0]   handler_pc_o,
    input logic [5:0]          mask_o,
    input logic [2:0]          mode_o
);
    localparam int NTOT = NUM_CRIT + NUM_EXC + 4;

    // R4
    crit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|crit_req_i) && !sr_load_i) |-> (acc_o && evt_cls_o == CLS_CRIT));

    // R5
    pc_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (((handler_pc_o & evba_i) == evba_i) &&
                   (handler_pc_o[ADDR_W-1:OFS_W] == evba_i[ADDR_W-1:OFS_W])));

    // R3
    glb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && mask_o[MB_GLB]) |-> (evt_cls_o == CLS_CRIT));

    // R6
    exc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && evt_cls_o != CLS_INT) |=> (mask_o == MASK_ALL));

    // R7
    int_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && evt_cls_o == CLS_INT) |=>
            (mask_o[0] && mode_o == 3'(NTOT + 1 - int'($past(evt_id_o)))));

    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load_i |=> (mask_o == $past(sr_mask_i) && mode_o == $past(sr_mode_i)));

    // R9
    load_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load_i |-> !acc_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_o && !sr_load_i) |=> ($stable(mask_o) && $stable(mode_o)));

endmodule

bind evu_top evu_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_W    (OFS_W),
    .NUM_CRIT (NUM_CRIT),
    .NUM_EXC  (NUM_EXC),
    .ID_W     (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .crit_req_i   (crit_req_i),
    .sr_load_i    (sr_load_i),
    .sr_mask_i    (sr_mask_i),
    .sr_mode_i    (sr_mode_i),
    .evba_i       (evba_i),
    .acc_o        (acc_o),
    .evt_cls_o    (evt_cls_o),
    .evt_id_o     (evt_id_o),
    .handler_pc_o (handler_pc_o),
    .mask_o       (mask_o),
    .mode_o       (mode_o)
);

// File: tb/sim_evu_top.sv
module sim_evu_top;
    localparam int AW   = 32;
    localparam int OW   = 14;
    localparam int NC   = 2;
    localparam int NE   = 3;
    localparam int OFS0 = 'h20;
    localparam int STR  = 'h80;
    localparam int IDW  = $clog2(NC + NE + 4);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   crit_req = '0;
    logic [NE-1:0]   exc_req = '0;
    logic [3:0]      int_req = '0;
    logic            sr_load = 1'b0;
    logic [5:0]      sr_mask = '0;
    logic [2:0]      sr_mode = '0;
    logic [AW-1:0]   evba = '0;
    logic [4*OW-1:0] autovec = '0;
    logic            acc;
    logic [1:0]      cls;
    logic [IDW-1:0]  id;
    logic [AW-1:0]   pc;
    logic [5:0]      mask;
    logic [2:0]      mode;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [5:0] m_mask;
    logic [2:0] m_mode;
    bit         e_acc;
    int         e_cls, e_id, e_lvl;
    logic [AW-1:0] e_pc;

    always #5 clk = ~clk;

    evu_top #(
        .ADDR_W (AW), .OFS_W (OW), .NUM_CRIT (NC), .NUM_EXC (NE),
        .EXC_OFS0 (OFS0), .EXC_STRIDE (STR)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .crit_req_i (crit_req), .exc_req_i (exc_req),
        .int_req_i (int_req), .sr_load_i (sr_load), .sr_mask_i (sr_mask),
        .sr_mode_i (sr_mode), .evba_i (evba), .autovec_i (autovec),
        .acc_o (acc), .evt_cls_o (cls), .evt_id_o (id), .handler_pc_o (pc),
        .mask_o (mask), .mode_o (mode)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] fix_ofs(input int e);
        return OW'(OFS0 + e * STR);
    endfunction

    task automatic compute_exp();
        e_acc = 0; e_cls = 0; e_id = 0; e_lvl = 0; e_pc = '0;
        if (!sr_load) begin
            for (int i = 0; i < NC && !e_acc; i++)
                if (crit_req[i]) begin e_acc = 1; e_cls = 1; e_id = i; end
            for (int j = 0; j < NE && !e_acc; j++)
                if (exc_req[j] && !m_mask[4] && !m_mask[5]) begin
                    e_acc = 1; e_cls = 2; e_id = NC + j;
                end
            for (int k = 3; k >= 0 && !e_acc; k--)
                if (int_req[k] && !m_mask[k] && !m_mask[5]) begin
                    e_acc = 1; e_cls = 3; e_id = NC + NE + 3 - k; e_lvl = k;
                end
        end
        if (e_acc) begin
            if (e_cls == 3) e_pc = evba | {{(AW-OW){1'b0}}, autovec[e_lvl*OW +: OW]};
            else            e_pc = evba | {{(AW-OW){1'b0}}, fix_ofs(e_id)};
        end
    endtask

    task automatic run_cycle();
        #1;
        compute_exp();
        chk(acc == e_acc, "R3 accept (R4/R8)", 64'(acc), 64'(e_acc));
        if (e_acc) begin
            chk(int'(cls) == e_cls, "R2 class", 64'(cls), 64'(e_cls));
            chk(int'(id) == e_id, "R2 event number", 64'(id), 64'(e_id));
            chk(pc == e_pc, "R5 handler address", 64'(pc), 64'(e_pc));
        end
        chk(mask == m_mask, "R6 mask field (R9/R10)", 64'(mask), 64'(m_mask));
        chk(mode == m_mode, "R7 mode field (R9/R10)", 64'(mode), 64'(m_mode));
        @(posedge clk);
        if (sr_load) begin
            m_mask = sr_mask; m_mode = sr_mode;
        end else if (e_acc) begin
            if (e_cls != 3) begin
                m_mask = 6'h3F;
                m_mode = (e_cls == 1) ? 3'd7 : 3'd6;
            end else begin
                m_mask = m_mask | 6'((1 << (e_lvl + 1)) - 1);
                m_mode = 3'(2 + e_lvl);
            end
        end
        @(negedge clk);
    endtask

    task automatic clear_in();
        crit_req = '0; exc_req = '0; int_req = '0; sr_load = 0;
    endtask

    task automatic load_sr(input logic [5:0] mk, input logic [2:0] md);
        clear_in(); sr_load = 1; sr_mask = mk; sr_mode = md;
        run_cycle();
        sr_load = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_mask = 6'h3F; m_mode = 3'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mask == 6'h3F, "R1 reset mask", 64'(mask), 64'h3F);
        chk(mode == 3'd1, "R1 reset mode", 64'(mode), 64'd1);
        rst_n = 1;
        @(negedge clk);
        chk(mask == 6'h3F && mode == 3'd1, "R1 after release", 64'({mask, mode}), 64'({6'h3F, 3'd1}));

        evba = 32'h8000_0030;
        autovec = {14'h0444, 14'h0333, 14'h0222, 14'h0111};
        // R3/R8: all masked, interrupts and exceptions stay pending, nothing changes
        int_req = 4'hF; exc_req = 3'b111;
        run_cycle();
        chk(acc == 1'b0 && mask == 6'h3F, "R8 masked request kept nothing", 64'({acc, mask}), 64'h3F);
        // R4: critical accepted with all masks set
        crit_req = 2'b10;
        #1;
        chk(acc && id == IDW'(1), "R4 critical under full mask", 64'(id), 64'd1);
        run_cycle();
        // R9: load with requests pending, no acceptance in the load cycle
        clear_in(); sr_load = 1; sr_mask = 6'h00; sr_mode = 3'd1; int_req = 4'h8;
        #1;
        chk(acc == 1'b0, "R9 no accept in load cycle", 64'(acc), 64'd0);
        run_cycle();
        chk(mask == 6'h00, "R9 loaded mask", 64'(mask), 64'h0);
        // R2/R5: exception 0 beats INT3; address is OR not sum
        clear_in(); exc_req = 3'b001; int_req = 4'h8;
        #1;
        chk(pc == 32'h8000_0130, "R5 OR not add", 64'(pc), 64'h8000_0130);
        chk(id == IDW'(NC), "R2 exception above INT3", 64'(id), 64'(NC));
        run_cycle();
        // R6/R7 exception update
        chk(mask == 6'h3F && mode == 3'd6, "R6 exception mask/mode", 64'({mask, mode}), 64'({6'h3F, 3'd6}));
        // R2/R6/R7: INT2 beats INT0
        load_sr(6'h00, 3'd1);
        int_req = 4'b0101;
        #1;
        chk(acc && pc == (evba | 32'h0333), "R5 autovector level 2", 64'(pc), 64'(evba | 32'h0333));
        run_cycle();
        chk(mask == 6'b000111 && mode == 3'd4, "R6 INT2 fills levels 2..0", 64'({mask, mode}), 64'({6'b000111, 3'd4}));
        // R8: held INT2 now masked, INT0 also masked: no acceptance
        run_cycle();
        chk(acc == 1'b0 && mask == 6'b000111, "R10 hold while masked", 64'({acc, mask}), 64'({1'b0, 6'b000111}));
        // R8: held request accepted once mask cleared
        load_sr(6'h00, 3'd1);
        int_req = 4'b0001;
        run_cycle();
        chk(mask == 6'b000001 && mode == 3'd2, "R7 INT0 mode", 64'({mask, mode}), 64'({6'b000001, 3'd2}));
        // R3: global mask alone blocks exception and interrupts
        load_sr(6'b100000, 3'd1);
        exc_req = 3'b100; int_req = 4'hF;
        run_cycle();
        chk(mask == 6'b100000, "R3 global mask blocks", 64'(mask), 64'h20);
        clear_in();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            crit_req = (($urandom % 8) == 0) ? NC'($urandom) : '0;
            exc_req  = (($urandom % 3) == 0) ? NE'($urandom) : '0;
            int_req  = 4'($urandom);
            sr_load  = (($urandom % 5) == 0);
            sr_mask  = (($urandom % 2) == 0) ? 6'h00 : 6'($urandom);
            sr_mode  = 3'($urandom);
            evba     = $urandom;
            autovec  = {$urandom, $urandom};
            run_cycle();
        end
        clear_in();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule